// File: doc/BRIEF.md
# Status Register Bit-Set Unit

This unit carries out the "OR an immediate into the machine status register" operation of a small 32-bit processor core. When an operation strobe arrives it hands back the status value as it stood before the operation, for writeback to a destination register, and merges the immediate mask into the status register. Zero bits in the mask leave the matching status bits alone.

Privilege is checked first. With the memory-management option switched on and the core in user mode, only the carry-only mask is allowed. Any other mask is refused: nothing is written back, the status register does not change, and a one-cycle exception pulse is raised together with a fixed cause code.

The carry bit takes effect in the same cycle as the operation. The other bits reach the architectural register one clock later, but the status view forwards them, so a read in the next cycle already shows the complete update. In low-latency interrupt mode, setting the interrupt-enable bit drives an acknowledge code for one cycle.

Top module: `stat_bitset_unit`

## Requirements
- R1: While reset is held and just after it is released, `stat_arch` and `stat_view` equal the `RESET_VAL` parameter. `wb_valid`, `carry_now`, `exc_pulse` and `irq_ack` are all 0, and `exc_code` is 5'b00000.
- R2: A permitted operation sampled at clock edge N raises `wb_valid` for exactly the cycle after edge N. In that cycle `wb_data` holds the `stat_view` value from the cycle in which the operation was presented.
- R3: After edge N of a permitted operation, `stat_view` equals its previous value bitwise ORed with the effective mask. Mask bits of 0 leave status bits unchanged.
- R4: The carry bit is bit 2 (mask value 0x0004). `carry_now` shows the new carry combinationally in the cycle the operation is presented. `stat_arch[2]` holds it after edge N.
- R5: Non-carry bits set by an operation at edge N appear in `stat_arch` only after edge N+1. `stat_view` already includes them after edge N, including when a second operation follows back-to-back.
- R6: With `mmu_on`=1 and `user_mode`=1, an effective mask other than 0x0004 is refused. In the same cycle `exc_pulse` is 1 and `exc_code` is 5'b00111. No writeback follows and the status does not change. At all other times `exc_pulse` is 0 and `exc_code` is 5'b00000.
- R7: The carry-only mask 0x0004 is permitted in user mode with `mmu_on`=1. Any mask is permitted when `mmu_on`=0, whatever the value of `user_mode`.
- R8: With `mmu_on`=1 all 15 mask bits (0..14) are effective. With `mmu_on`=0 mask bit 14 is forced to 0. Status bits 15 and above never change through an operation.
- R9: On a permitted operation with `fast_irq`=1 and mask bit 1 (value 0x0002) set, `irq_ack` is 2'b11 in the cycle after edge N. Otherwise it rests at 2'b00.
- R10: With the `ENABLE_OP` parameter at 0 the operation is absent. A strobe produces no writeback, no exception, no acknowledge and no status change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation strobe, one cycle per operation |
| op_imm | input | IMM_W (15) | Bit-set mask |
| user_mode | input | 1 | Core is in user mode |
| mmu_on | input | 1 | Memory-management option configured |
| fast_irq | input | 1 | Low-latency interrupt mode configured |
| wb_valid | output | 1 | Writeback of the old status is valid |
| wb_data | output | DATA_W (32) | Status value before the operation |
| stat_arch | output | DATA_W (32) | Architecturally committed status register |
| stat_view | output | DATA_W (32) | Status read value with pending bits forwarded |
| carry_now | output | 1 | Effective carry, including a same-cycle set |
| exc_pulse | output | 1 | Privileged-operation exception pulse |
| exc_code | output | 5 | Exception cause code, 5'b00111 when refused |
| irq_ack | output | 2 | Interrupt acknowledge code |

## Verification
`carry_now`, `exc_pulse` and `exc_code` are combinational. The driver checks them 1 ns after it applies the operation at the falling edge, while the strobe is still held. `wb_valid`, `wb_data`, `irq_ack`, `stat_view` and the carry bit of `stat_arch` are due one edge after the operation. The monitor samples them 2 ns after the rising edge, against an item the driver queued for that operation. The full non-carry update of `stat_arch` is due a further edge later, and the driver checks it at the falling edge that follows one idle edge.

// File: rtl/sbs_pkg.sv
package sbs_pkg;

  localparam logic [4:0] EC_PRIV  = 5'b00111;
  localparam logic [4:0] EC_NONE  = 5'b00000;
  localparam logic [1:0] ACK_IRQ  = 2'b11;
  localparam logic [1:0] ACK_IDLE = 2'b00;

  // Keep only the low 'width' bits of a mask.
  function automatic logic [31:0] clip_to_width(input logic [31:0] imm,
                                                input int unsigned width);
    logic [31:0] keep;
    keep = (width >= 32) ? 32'hFFFF_FFFF : ((32'h1 << width) - 32'h1);
    return imm & keep;
  endfunction

  // A user-mode request is refused unless it touches the carry only.
  function automatic logic privileged_refusal(input logic [31:0] imm,
                                              input logic        user,
                                              input logic        mmu,
                                              input int unsigned carry_idx);
    return mmu && user && (imm != (32'h1 << carry_idx));
  endfunction

  function automatic logic [31:0] merge_bits(input logic [31:0] old_val,
                                             input logic [31:0] set_val);
    return old_val | set_val;
  endfunction

endpackage

// File: rtl/sbs_gate.sv
module sbs_gate
  import sbs_pkg::*;
#(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned IMM_W     = 15,
  parameter int unsigned CARRY_IDX = 2,
  parameter bit          ENABLE_OP = 1'b1
) (
  input  logic              op_valid,
  input  logic [IMM_W-1:0]  op_imm,
  input  logic              user_mode,
  input  logic              mmu_on,
  output logic              fire,
  output logic [DATA_W-1:0] set_bits,
  output logic              exc_pulse,
  output logic [4:0]        exc_code
);

  localparam int unsigned NARROW_W = IMM_W - 1;

  logic [31:0] imm_ext;
  logic [31:0] imm_clip;
  logic        refuse;

  assign imm_ext  = 32'(op_imm);
  assign imm_clip = clip_to_width(imm_ext, mmu_on ? IMM_W : NARROW_W);

  generate
    if (ENABLE_OP) begin : g_present
      assign refuse = op_valid && privileged_refusal(imm_clip, user_mode, mmu_on, CARRY_IDX);
      assign fire   = op_valid && !refuse;
    end else begin : g_absent
      assign refuse = 1'b0;
      assign fire   = 1'b0;
    end
  endgenerate

  assign set_bits  = fire ? DATA_W'(imm_clip) : '0;
  assign exc_pulse = refuse;
  assign exc_code  = refuse ? EC_PRIV : EC_NONE;

endmodule

// File: rtl/sbs_commit.sv
module sbs_commit
  import sbs_pkg::*;
#(
  parameter int unsigned       DATA_W    = 32,
  parameter int unsigned       CARRY_IDX = 2,
  parameter logic [DATA_W-1:0] RESET_VAL = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] set_bits,
  output logic [DATA_W-1:0] stat_arch,
  output logic [DATA_W-1:0] stat_view,
  output logic              carry_now
);

  localparam logic [DATA_W-1:0] CARRY_M = DATA_W'(1) << CARRY_IDX;

  logic [DATA_W-1:0] arch_q;
  logic [DATA_W-1:0] pend_q;
  logic [DATA_W-1:0] arch_next;

  // Carry lands now; bits pending from the last operation land as well.
  assign arch_next = DATA_W'(merge_bits(32'(arch_q), 32'(pend_q | (set_bits & CARRY_M))));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      arch_q <= RESET_VAL;
      pend_q <= '0;
    end else begin
      arch_q <= arch_next;
      pend_q <= set_bits & ~CARRY_M;
    end
  end

  assign stat_arch = arch_q;
  assign stat_view = arch_q | pend_q;
  assign carry_now = arch_q[CARRY_IDX] | set_bits[CARRY_IDX];

  assert_pend_lands_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q != '0) |=> ((arch_q & $past(pend_q)) == $past(pend_q)));

  assert_view_grows_R3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat_view & $past(stat_view)) == $past(stat_view)));

  assert_carry_lands_R4: assert property (@(posedge clk) disable iff (!rst_n)
    set_bits[CARRY_IDX] |=> arch_q[CARRY_IDX]);

endmodule

// File: rtl/sbs_result.sv
module sbs_result
  import sbs_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic              ie_set,
  input  logic              fast_irq,
  input  logic [DATA_W-1:0] old_val,
  output logic              wb_valid,
  output logic [DATA_W-1:0] wb_data,
  output logic [1:0]        irq_ack
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wb_valid <= 1'b0;
      wb_data  <= '0;
      irq_ack  <= ACK_IDLE;
    end else begin
      wb_valid <= fire;
      wb_data  <= fire ? old_val : '0;
      irq_ack  <= (fire && fast_irq && ie_set) ? ACK_IRQ : ACK_IDLE;
    end
  end

  assert_ack_with_wb_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack != ACK_IDLE) |-> wb_valid);

  assert_ack_code_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack == ACK_IDLE) || (irq_ack == ACK_IRQ));

endmodule

// File: rtl/stat_bitset_unit.sv
module stat_bitset_unit
  import sbs_pkg::*;
#(
  parameter int unsigned       DATA_W    = 32,
  parameter int unsigned       IMM_W     = 15,
  parameter int unsigned       CARRY_IDX = 2,
  parameter int unsigned       IE_IDX    = 1,
  parameter bit                ENABLE_OP = 1'b1,
  parameter logic [DATA_W-1:0] RESET_VAL = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [IMM_W-1:0]  op_imm,
  input  logic              user_mode,
  input  logic              mmu_on,
  input  logic              fast_irq,
  output logic              wb_valid,
  output logic [DATA_W-1:0] wb_data,
  output logic [DATA_W-1:0] stat_arch,
  output logic [DATA_W-1:0] stat_view,
  output logic              carry_now,
  output logic              exc_pulse,
  output logic [4:0]        exc_code,
  output logic [1:0]        irq_ack
);

  logic              fire;
  logic [DATA_W-1:0] set_bits;

  sbs_gate #(
    .DATA_W(DATA_W), .IMM_W(IMM_W), .CARRY_IDX(CARRY_IDX), .ENABLE_OP(ENABLE_OP)
  ) i_gate (
    .op_valid (op_valid),
    .op_imm   (op_imm),
    .user_mode(user_mode),
    .mmu_on   (mmu_on),
    .fire     (fire),
    .set_bits (set_bits),
    .exc_pulse(exc_pulse),
    .exc_code (exc_code)
  );

  sbs_commit #(
    .DATA_W(DATA_W), .CARRY_IDX(CARRY_IDX), .RESET_VAL(RESET_VAL)
  ) i_commit (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_bits (set_bits),
    .stat_arch(stat_arch),
    .stat_view(stat_view),
    .carry_now(carry_now)
  );

  sbs_result #(
    .DATA_W(DATA_W)
  ) i_result (
    .clk     (clk),
    .rst_n   (rst_n),
    .fire    (fire),
    .ie_set  (set_bits[IE_IDX]),
    .fast_irq(fast_irq),
    .old_val (stat_view),
    .wb_valid(wb_valid),
    .wb_data (wb_data),
    .irq_ack (irq_ack)
  );

  assert_refused_no_wb_R6: assert property (@(posedge clk) disable iff (!rst_n)
    exc_pulse |=> !wb_valid);

  assert_refused_no_change_R6: assert property (@(posedge clk) disable iff (!rst_n)
    exc_pulse |=> (stat_view == $past(stat_view)));

  assert_wb_is_subset_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> ((stat_view & wb_data) == wb_data));

  assert_upper_untouched_R8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (stat_view[DATA_W-1:IMM_W] == $past(stat_view[DATA_W-1:IMM_W])));

  assert_absent_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !ENABLE_OP |-> (!wb_valid && !exc_pulse && (stat_view == RESET_VAL)));

endmodule

// File: tb/test_stat_bitset_unit.sv
module test_stat_bitset_unit;

  localparam logic [31:0] RST_V = 32'h0001_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [14:0] op_imm = '0;
  logic        user_mode = 1'b0, mmu_on = 1'b0, fast_irq = 1'b0;

  logic        wb_valid, carry_now, exc_pulse;
  logic [31:0] wb_data, stat_arch, stat_view;
  logic [4:0]  exc_code;
  logic [1:0]  irq_ack;

  logic        off_wb, off_carry, off_exc;
  logic [31:0] off_wbd, off_arch, off_view;
  logic [4:0]  off_code;
  logic [1:0]  off_ack;

  always #4 clk = ~clk;  // 125 MHz

  stat_bitset_unit #(.RESET_VAL(RST_V)) i_stat_bitset_unit (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_imm(op_imm),
    .user_mode(user_mode), .mmu_on(mmu_on), .fast_irq(fast_irq),
    .wb_valid(wb_valid), .wb_data(wb_data), .stat_arch(stat_arch),
    .stat_view(stat_view), .carry_now(carry_now), .exc_pulse(exc_pulse),
    .exc_code(exc_code), .irq_ack(irq_ack));

  stat_bitset_unit #(.ENABLE_OP(1'b0)) i_stat_bitset_unit_off (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_imm(op_imm),
    .user_mode(user_mode), .mmu_on(mmu_on), .fast_irq(fast_irq),
    .wb_valid(off_wb), .wb_data(off_wbd), .stat_arch(off_arch),
    .stat_view(off_view), .carry_now(off_carry), .exc_pulse(off_exc),
    .exc_code(off_code), .irq_ack(off_ack));

  typedef struct {
    logic        wb;
    logic [31:0] data;
    logic [1:0]  ack;
    logic [31:0] view;
    logic [31:0] arch;
  } exp_t;

  exp_t        q[$];
  int          n_vec = 0;
  int          n_bad = 0;
  logic [31:0] mview;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Driver: present one operation at a falling edge, check the
  // combinational outputs, queue what is due after the next rising edge.
  task automatic apply(input logic [14:0] imm, input logic um,
                       input logic mmu, input logic fast, input logic hold);
    logic [31:0] eff;
    logic        refused;
    exp_t        it;
    @(negedge clk);
    op_imm = imm; user_mode = um; mmu_on = mmu; fast_irq = fast; op_valid = 1'b1;
    eff     = mmu ? 32'(imm) : 32'(imm & 15'h3FFF);
    refused = mmu && um && (eff != 32'h4);
    #1;
    chk("R6", "exc_pulse", 32'(exc_pulse), 32'(refused));
    chk("R6", "exc_code", 32'(exc_code), refused ? 32'h7 : 32'h0);
    chk("R4", "carry_now", 32'(carry_now), 32'(mview[2] | (!refused & eff[2])));
    chk("R10", "off exc_pulse", 32'(off_exc), 32'h0);
    it.wb   = !refused;
    it.data = mview;
    it.ack  = (!refused && fast && eff[1]) ? 2'b11 : 2'b00;
    it.view = refused ? mview : (mview | eff);
    it.arch = mview | (refused ? 32'h0 : (eff & 32'h4));
    mview   = it.view;
    q.push_back(it);
    if (!hold) begin
      @(negedge clk);
      op_valid = 1'b0;
      @(negedge clk);
      chk("R5", "stat_arch settled", stat_arch, mview);
    end
  endtask

  // Monitor: what the edge after an operation must show.
  always @(posedge clk) begin
    logic was;
    exp_t it;
    was = op_valid && rst_n;
    #2;
    if (was) begin
      if (q.size() == 0) begin
        chk("R2", "queue underrun", 32'h1, 32'h0);
      end else begin
        it = q.pop_front();
        chk("R2", "wb_valid", 32'(wb_valid), 32'(it.wb));
        if (it.wb) chk("R2", "wb_data", wb_data, it.data);
        chk("R9", "irq_ack", 32'(irq_ack), 32'(it.ack));
        chk("R3", "stat_view", stat_view, it.view);
        chk("R4", "stat_arch", stat_arch, it.arch);
        chk("R10", "off wb_valid", 32'(off_wb), 32'h0);
        chk("R10", "off stat_view", off_view, 32'h0);
      end
    end else if (rst_n) begin
      if (wb_valid !== 1'b0 || irq_ack !== 2'b00)
        chk("R2", "idle quiet", {wb_valid, 29'h0, irq_ack}, 32'h0);
    end
  end

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    #(8 * 100000);
    chk("R1", "watchdog", 32'h1, 32'h0);
    finish_run();
  end

  initial begin
    mview = RST_V;
    repeat (3) @(negedge clk);
    chk("R1", "stat_arch in reset", stat_arch, RST_V);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "stat_arch", stat_arch, RST_V);
    chk("R1", "stat_view", stat_view, RST_V);
    chk("R1", "wb_valid", 32'(wb_valid), 32'h0);
    chk("R1", "carry_now", 32'(carry_now), 32'h0);
    chk("R1", "exc", {exc_pulse, 26'h0, exc_code}, 32'h0);
    chk("R1", "irq_ack", 32'(irq_ack), 32'h0);

    apply(15'h0010, 1'b0, 1'b0, 1'b0, 1'b0);  // R3 plain set
    apply(15'h0000, 1'b0, 1'b0, 1'b0, 1'b0);  // R3 zero mask
    apply(15'h0100, 1'b1, 1'b1, 1'b0, 1'b0);  // R6 refused
    apply(15'h0006, 1'b1, 1'b1, 1'b1, 1'b0);  // R6 refused, no ack
    apply(15'h0004, 1'b1, 1'b1, 1'b0, 1'b0);  // R7 carry exemption, R4
    apply(15'h0200, 1'b1, 1'b0, 1'b0, 1'b0);  // R7 user mode without MMU
    apply(15'h4000, 1'b0, 1'b0, 1'b0, 1'b0);  // R8 bit 14 dropped
    chk("R8", "bit14 without MMU", 32'(stat_view[14]), 32'h0);
    apply(15'h4000, 1'b0, 1'b1, 1'b0, 1'b0);  // R8 bit 14 kept
    chk("R8", "bit14 with MMU", 32'(stat_view[14]), 32'h1);
    apply(15'h0002, 1'b0, 1'b0, 1'b0, 1'b0);  // R9 no ack without mode
    apply(15'h0002, 1'b0, 1'b0, 1'b1, 1'b0);  // R9 ack
    apply(15'h0009, 1'b0, 1'b0, 1'b1, 1'b0);  // R9 no ack without IE bit
    apply(15'h0020, 1'b0, 1'b0, 1'b0, 1'b1);  // R5 back-to-back
    apply(15'h0040, 1'b0, 1'b0, 1'b0, 1'b1);
    apply(15'h0080, 1'b0, 1'b0, 1'b0, 1'b0);
    apply(15'h7FFF, 1'b0, 1'b1, 1'b0, 1'b0);  // R8 upper bits untouched
    chk("R8", "upper bits", stat_view & 32'hFFFF_8000, RST_V);
    chk("R10", "off stat_arch", off_arch, 32'h0);
    repeat (2) @(negedge clk);
    chk("R2", "queue drained", 32'(q.size()), 32'h0);
    finish_run();
  end

endmodule